// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Flags

This block receives asynchronous serial frames on a single input line. An external rate generator supplies a tick at sixteen times the bit rate. The line passes through a two-stage synchronizer. A frame engine finds the start bit, votes on three samples taken near the middle of every bit, and builds the word in a shift register. The finished word goes into one holding buffer. Beside that buffer the block keeps seven sticky status flags: data available, framing error, noise, overrun, parity error, break and idle line. Each flag can be enabled onto one shared interrupt output.

The received data leaves through a valid/ready port. `rx_valid` is the data-available flag, and a one-cycle pulse on `rx_ready` consumes the word. The host applies back-pressure by not pulsing `rx_ready`. The word then stays in the buffer and valid stays high. If another frame completes during that time, it is an overrun: the buffered word is kept and the incoming word is discarded. In DMA mode the port is served by `dma_req`/`dma_ack` instead of `rx_ready`. An optional active-low request-to-send output signals when the buffer is free. A LIN-style mode reports break frames on their own flag and does not treat them as bad data.

Top module: `uart_rx_status`

## Requirements
- R1: Reception runs only while `blk_en` and `rx_en` are both high. While either is low, the frame engine is held idle, and a frame sent on the line during that time sets no flag.
- R2: Each frame is one low start bit, then 8 data bits (`nine_bit`=0) or 9 data bits (`nine_bit`=1) sent LSB first, an optional parity bit, and one stop bit. On the valid stop bit the word appears on `rx_data` (zero-extended in 8-bit mode) and `rx_valid` rises.
- R3: A low level must still read low at mid-bit to count as a start bit. A low pulse shorter than half a bit is ignored and leaves `rx_valid` low.
- R4: Each bit value is the majority of three samples at ticks 7, 8 and 9 of the bit. If the three samples differ in any bit of the frame, `err_noise` is set and the voted word is still delivered.
- R5: With `par_en` high, a parity bit follows the data. The parity is even when `par_odd`=0 and odd when `par_odd`=1. A mismatch sets `err_parity`, and the word is still delivered.
- R6: A stop bit sampled low sets `err_frame` in the same cycle as `rx_valid`, and the invalid word is still placed in the buffer.
- R7: A break frame is one in which every bit, stop bit included, is low. With `lin_en`=0 it is handled as a framing error carrying data 0. With `lin_en`=1 it sets `brk_flag` only: it leaves the buffer, `rx_valid` and `err_frame` untouched.
- R8: If a frame completes while `rx_valid` or `err_over` is high, `err_over` is set. The buffered word stays on `rx_data`, and this frame and every later one are discarded until the flags are cleared.
- R9: `rx_valid` clears on `rx_ready` when `dma_en`=0, and on `rdy_wclr` in any mode. Neither input changes the error flags on its own.
- R10: With `dma_en`=1, `dma_req` follows `rx_valid`. `dma_ack` clears the flag, and `rx_ready` does not clear it.
- R11: A `stat_rd` pulse followed later by an `rx_ready` pulse clears `err_frame`, `err_noise`, `err_over`, `err_parity`, `brk_flag` and `idle_flag`.
- R12: After a frame, if the line then stays high for one whole frame time, counted in ticks, `idle_flag` is set once.
- R13: `irq` is high when any flag is high together with its enable. The enables are `ie_rdy` for data available (ignored in DMA mode), `ie_err` for the four error flags, `ie_brk` for break and `ie_idle` for idle.
- R14: With `flow_en`=1, `rts_n` is low exactly while `rx_valid` is low. With `flow_en`=0, `rts_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| rx_in | input | 1 | Serial line, idles high |
| blk_en | input | 1 | Block enable |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 1: nine data bits, 0: eight |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1: odd parity, 0: even |
| lin_en | input | 1 | Break frames go to the break flag |
| dma_en | input | 1 | DMA handshake serves the data port |
| flow_en | input | 1 | Drive request-to-send from buffer state |
| ie_rdy | input | 1 | Interrupt enable, data available |
| ie_err | input | 1 | Interrupt enable, error flags |
| ie_brk | input | 1 | Interrupt enable, break |
| ie_idle | input | 1 | Interrupt enable, idle |
| stat_rd | input | 1 | Status read pulse, arms error clear |
| rx_ready | input | 1 | Software consume pulse |
| rdy_wclr | input | 1 | Write-zero clear of data available |
| dma_ack | input | 1 | DMA read pulse |
| rx_data | output | 9 | Buffered word |
| rx_valid | output | 1 | Data available flag |
| err_frame | output | 1 | Framing error flag |
| err_noise | output | 1 | Noise flag |
| err_over | output | 1 | Overrun flag |
| err_parity | output | 1 | Parity error flag |
| brk_flag | output | 1 | Break flag |
| idle_flag | output | 1 | Idle line flag |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Combined interrupt |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
A wrong bit counter or sample point in the frame engine shows on `rx_data` in the same frame: the word arrives shifted or with bits swapped, or the error flags come up on a clean frame, no later than one stop bit after the frame ends. A flag register that sets or clears at the wrong time shows on `rx_valid`, `rts_n`, `dma_req` or `irq` within a cycle of the triggering pulse. A buffer gated wrongly during overrun shows on `rx_data` as soon as the following frame ends.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } rx_phase_e;

  typedef struct packed {
    logic done;
    logic ferr;
    logic noise;
    logic perr;
    logic brk;
  } rx_status_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b1;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              nine_bit,
  input  logic              par_en,
  input  logic              par_odd,
  output rx_status_t        st,
  output logic [DATA_W-1:0] word,
  output logic              idle_pulse
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam int IW  = $clog2((DATA_W + 3) * OVS + 1);
  localparam int MID = OVS / 2;

  rx_phase_e         phase;
  logic [CW-1:0]     tcnt;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-1:0] shreg;
  logic              s_a, s_b, par_acc, one_seen, noise_acc, armed, idle_pend;
  logic [IW-1:0]     idle_cnt;

  logic          vote, disagree;
  logic [BW-1:0] nbits;
  logic [IW-1:0] frame_ticks;

  assign vote        = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
  assign disagree    = !((s_a == s_b) && (s_b == rx_s));
  assign nbits       = nine_bit ? BW'(DATA_W) : BW'(DATA_W - 1);
  assign frame_ticks = IW'((32'(nbits) + 2 + 32'(par_en)) * OVS);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase      <= PH_IDLE;
      tcnt       <= '0;
      bcnt       <= '0;
      shreg      <= '0;
      s_a        <= 1'b1;
      s_b        <= 1'b1;
      par_acc    <= 1'b0;
      one_seen   <= 1'b0;
      noise_acc  <= 1'b0;
      armed      <= 1'b0;
      idle_pend  <= 1'b0;
      idle_cnt   <= '0;
      st         <= '0;
      word       <= '0;
      idle_pulse <= 1'b0;
    end else begin
      st.done    <= 1'b0;
      idle_pulse <= 1'b0;
      if (tick) begin
        if (phase == PH_IDLE) begin
          if (rx_s) begin
            armed <= 1'b1;
            if (idle_pend) begin
              if (idle_cnt == frame_ticks - 1'b1) begin
                idle_pulse <= 1'b1;
                idle_pend  <= 1'b0;
                idle_cnt   <= '0;
              end else begin
                idle_cnt <= idle_cnt + 1'b1;
              end
            end
          end else begin
            idle_cnt <= '0;
            if (armed) begin
              phase     <= PH_START;
              tcnt      <= CW'(1);
              armed     <= 1'b0;
              bcnt      <= '0;
              par_acc   <= 1'b0;
              one_seen  <= 1'b0;
              noise_acc <= 1'b0;
            end
          end
        end else begin
          tcnt <= (tcnt == CW'(OVS - 1)) ? '0 : tcnt + 1'b1;
          if (tcnt == CW'(MID - 1)) s_a <= rx_s;
          if (tcnt == CW'(MID))     s_b <= rx_s;
          if (tcnt == CW'(MID + 1)) begin
            noise_acc <= noise_acc | disagree;
            unique case (phase)
              PH_START: if (vote) phase <= PH_IDLE;
              PH_DATA: begin
                shreg    <= {vote, shreg[DATA_W-1:1]};
                par_acc  <= par_acc ^ vote;
                one_seen <= one_seen | vote;
                bcnt     <= bcnt + 1'b1;
              end
              PH_PAR: begin
                par_acc  <= par_acc ^ vote;
                one_seen <= one_seen | vote;
              end
              PH_STOP: begin
                st.done   <= 1'b1;
                st.ferr   <= !vote;
                st.noise  <= noise_acc | disagree;
                st.perr   <= par_en && (par_acc != par_odd);
                st.brk    <= !one_seen && !vote;
                word      <= nine_bit ? shreg : (shreg >> 1);
                phase     <= PH_IDLE;
                idle_pend <= 1'b1;
                idle_cnt  <= '0;
              end
              default: ;
            endcase
          end
          if (tcnt == CW'(OVS - 1)) begin
            unique case (phase)
              PH_START: phase <= PH_DATA;
              PH_DATA:  if (bcnt == nbits) phase <= par_en ? PH_PAR : PH_STOP;
              PH_PAR:   phase <= PH_STOP;
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_status_t        st,
  input  logic [DATA_W-1:0] word,
  input  logic              idle_pulse,
  input  logic              lin_en,
  input  logic              dma_en,
  input  logic              flow_en,
  input  logic              ie_rdy,
  input  logic              ie_err,
  input  logic              ie_brk,
  input  logic              ie_idle,
  input  logic              stat_rd,
  input  logic              rx_ready,
  input  logic              rdy_wclr,
  input  logic              dma_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_frame,
  output logic              err_noise,
  output logic              err_over,
  output logic              err_parity,
  output logic              brk_flag,
  output logic              idle_flag,
  output logic              dma_req,
  output logic              irq,
  output logic              rts_n
);
  logic stat_seen;
  logic data_frame, accept, over_hit, lin_brk, rd_clear, err_clear;

  assign lin_brk    = st.done && lin_en && st.brk;
  assign data_frame = st.done && !(lin_en && st.brk);
  assign accept     = data_frame && !rx_valid && !err_over;
  assign over_hit   = data_frame && (rx_valid || err_over);
  assign rd_clear   = (rx_ready && !dma_en) || rdy_wclr || (dma_ack && dma_en);
  assign err_clear  = rx_ready && stat_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      err_frame  <= 1'b0;
      err_noise  <= 1'b0;
      err_over   <= 1'b0;
      err_parity <= 1'b0;
      brk_flag   <= 1'b0;
      idle_flag  <= 1'b0;
      stat_seen  <= 1'b0;
    end else begin
      if (accept) rx_data <= word;

      if (accept)        rx_valid <= 1'b1;
      else if (rd_clear) rx_valid <= 1'b0;

      if (accept && st.ferr)       err_frame <= 1'b1;
      else if (err_clear)          err_frame <= 1'b0;
      if (accept && st.noise)      err_noise <= 1'b1;
      else if (err_clear)          err_noise <= 1'b0;
      if (accept && st.perr)       err_parity <= 1'b1;
      else if (err_clear)          err_parity <= 1'b0;
      if (over_hit)                err_over <= 1'b1;
      else if (err_clear)          err_over <= 1'b0;
      if (lin_brk)                 brk_flag <= 1'b1;
      else if (err_clear)          brk_flag <= 1'b0;
      if (idle_pulse)              idle_flag <= 1'b1;
      else if (err_clear)          idle_flag <= 1'b0;

      if (stat_rd)       stat_seen <= 1'b1;
      else if (rx_ready) stat_seen <= 1'b0;
    end
  end

  assign dma_req = dma_en && rx_valid;
  assign irq     = (rx_valid && ie_rdy && !dma_en)
                 || ((err_frame || err_noise || err_over || err_parity) && ie_err)
                 || (brk_flag && ie_brk)
                 || (idle_flag && ie_idle);
  assign rts_n   = flow_en && rx_valid;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DATA_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_in,
  input  logic              blk_en,
  input  logic              rx_en,
  input  logic              nine_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              lin_en,
  input  logic              dma_en,
  input  logic              flow_en,
  input  logic              ie_rdy,
  input  logic              ie_err,
  input  logic              ie_brk,
  input  logic              ie_idle,
  input  logic              stat_rd,
  input  logic              rx_ready,
  input  logic              rdy_wclr,
  input  logic              dma_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              err_frame,
  output logic              err_noise,
  output logic              err_over,
  output logic              err_parity,
  output logic              brk_flag,
  output logic              idle_flag,
  output logic              dma_req,
  output logic              irq,
  output logic              rts_n
);
  logic              rx_s, idle_pulse;
  rx_status_t        st;
  logic [DATA_W-1:0] word;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
  );

  uart_rx_frame #(.OVS(OVS), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(blk_en && rx_en), .tick(baud_tick),
    .rx_s(rx_s), .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
    .st(st), .word(word), .idle_pulse(idle_pulse)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .st(st), .word(word), .idle_pulse(idle_pulse),
    .lin_en(lin_en), .dma_en(dma_en), .flow_en(flow_en),
    .ie_rdy(ie_rdy), .ie_err(ie_err), .ie_brk(ie_brk), .ie_idle(ie_idle),
    .stat_rd(stat_rd), .rx_ready(rx_ready), .rdy_wclr(rdy_wclr), .dma_ack(dma_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_frame(err_frame),
    .err_noise(err_noise), .err_over(err_over), .err_parity(err_parity),
    .brk_flag(brk_flag), .idle_flag(idle_flag), .dma_req(dma_req),
    .irq(irq), .rts_n(rts_n)
  );
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_en,
  input logic              rx_en,
  input logic              lin_en,
  input logic              dma_en,
  input logic              flow_en,
  input logic              ie_rdy,
  input logic              ie_err,
  input logic              ie_brk,
  input logic              ie_idle,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              err_frame,
  input logic              brk_flag,
  input logic              dma_req,
  input logic              irq,
  input logic              rts_n
);
  logic off_now;
  assign off_now = !(blk_en && rx_en);

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    off_now && $past(off_now) |=> !$rose(rx_valid));

  assert_frame_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> $rose(rx_valid));

  assert_break_needs_lin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> $past(lin_en));

  assert_buffer_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> $stable(rx_data));

  assert_dma_req_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (rx_valid && dma_en));

  assert_irq_masked_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_rdy && !ie_err && !ie_brk && !ie_idle) |-> !irq);

  assert_rts_follows_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && flow_en |-> rts_n);
endmodule

bind uart_rx_status uart_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .rx_en(rx_en), .lin_en(lin_en),
  .dma_en(dma_en), .flow_en(flow_en), .ie_rdy(ie_rdy), .ie_err(ie_err),
  .ie_brk(ie_brk), .ie_idle(ie_idle), .rx_data(rx_data), .rx_valid(rx_valid),
  .err_frame(err_frame), .brk_flag(brk_flag), .dma_req(dma_req), .irq(irq),
  .rts_n(rts_n)
);

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic blk_en = 1'b1, rx_en = 1'b1, nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic lin_en = 1'b0, dma_en = 1'b0, flow_en = 1'b0;
  logic ie_rdy = 1'b0, ie_err = 1'b0, ie_brk = 1'b0, ie_idle = 1'b0;
  logic stat_rd = 1'b0, rx_ready = 1'b0, rdy_wclr = 1'b0, dma_ack = 1'b0;
  logic [8:0] rx_data;
  logic rx_valid, err_frame, err_noise, err_over, err_parity, brk_flag, idle_flag;
  logic dma_req, irq, rts_n;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  uart_rx_status uut (
    .clk(clk), .rst_n(rst_n), .baud_tick(1'b1), .rx_in(rx_in),
    .blk_en(blk_en), .rx_en(rx_en), .nine_bit(nine_bit), .par_en(par_en),
    .par_odd(par_odd), .lin_en(lin_en), .dma_en(dma_en), .flow_en(flow_en),
    .ie_rdy(ie_rdy), .ie_err(ie_err), .ie_brk(ie_brk), .ie_idle(ie_idle),
    .stat_rd(stat_rd), .rx_ready(rx_ready), .rdy_wclr(rdy_wclr), .dma_ack(dma_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .err_frame(err_frame),
    .err_noise(err_noise), .err_over(err_over), .err_parity(err_parity),
    .brk_flag(brk_flag), .idle_flag(idle_flag), .dma_req(dma_req),
    .irq(irq), .rts_n(rts_n)
  );

  typedef struct packed {
    logic       nine;
    logic       pen;
    logic       podd;
    logic       bad_par;
    logic       bad_stop;
    logic [8:0] data;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h13C},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1F0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h05A},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'h081},
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h066},
    '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h155}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input logic glitch);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      rx_in = (glitch && k == 8) ? ~v : v;
    end
  endtask

  task automatic send(input logic [8:0] d, input logic nine, input logic pen,
                      input logic podd, input logic bad_par, input logic bad_stop,
                      input int glitch_bit);
    int nb;
    logic p;
    nb = nine ? 9 : 8;
    p = ^(nine ? d : {1'b0, d[7:0]});
    if (podd) p = ~p;
    if (bad_par) p = ~p;
    drive_bit(1'b0, glitch_bit == 0);
    for (int i = 0; i < nb; i++) drive_bit(d[i], glitch_bit == i + 1);
    if (pen) drive_bit(p, 1'b0);
    drive_bit(!bad_stop, 1'b0);
    @(negedge clk);
    rx_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic clear_all();
    pulse(stat_rd);
    pulse(rx_ready);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset R2 valid", rx_valid, 0);
    check("reset R11 flags", {err_frame, err_noise, err_over, err_parity, brk_flag, idle_flag}, 0);
    check("reset R14 rts", rts_n, 0);
    check("reset R13 irq", irq, 0);
    repeat (4) @(negedge clk);

    // Vector walk: R2 data delivery, R5 parity, R6 framing
    for (int v = 0; v < NV; v++) begin
      nine_bit = VEC[v].nine;
      par_en   = VEC[v].pen;
      par_odd  = VEC[v].podd;
      send(VEC[v].data, VEC[v].nine, VEC[v].pen, VEC[v].podd, VEC[v].bad_par, VEC[v].bad_stop, -1);
      check("R2 valid", rx_valid, 1);
      check("R2 data", rx_data, VEC[v].nine ? VEC[v].data : {1'b0, VEC[v].data[7:0]});
      check("R5 parity flag", err_parity, VEC[v].bad_par);
      check("R6 frame flag", err_frame, VEC[v].bad_stop);
      check("R4 no noise", err_noise, 0);
      clear_all();
      check("R11 cleared", {rx_valid, err_frame, err_parity}, 0);
    end
    nine_bit = 1'b0; par_en = 1'b0; par_odd = 1'b0;

    // R3 short low pulse
    @(negedge clk); rx_in = 1'b0;
    repeat (3) @(negedge clk); rx_in = 1'b1;
    repeat (40) @(negedge clk);
    check("R3 glitch ignored", rx_valid, 0);
    send(9'h0C3, 0, 0, 0, 0, 0, -1);
    check("R3 frame after glitch", rx_data, 9'h0C3);
    clear_all();

    // R4 noise on data bit 0
    send(9'h00F, 0, 0, 0, 0, 0, 1);
    check("R4 voted data", rx_data, 9'h00F);
    check("R4 noise flag", err_noise, 1);
    clear_all();
    check("R4 noise cleared", err_noise, 0);

    // R8 overrun
    send(9'h011, 0, 0, 0, 0, 0, -1);
    send(9'h022, 0, 0, 0, 0, 0, -1);
    check("R8 over flag", err_over, 1);
    check("R8 old data kept", rx_data, 9'h011);
    pulse(rdy_wclr);
    @(negedge clk);
    send(9'h033, 0, 0, 0, 0, 0, -1);
    check("R8 later frame dropped", rx_valid, 0);
    check("R8 data still old", rx_data, 9'h011);
    clear_all();
    check("R11 over cleared", err_over, 0);
    send(9'h044, 0, 0, 0, 0, 0, -1);
    check("R8 receive resumes", rx_data, 9'h044);
    clear_all();

    // R9 write-zero clear keeps errors; lone read keeps errors
    send(9'h055, 0, 0, 0, 0, 1, -1);
    pulse(rdy_wclr);
    @(negedge clk);
    check("R9 wclr clears valid", rx_valid, 0);
    check("R9 wclr keeps error", err_frame, 1);
    pulse(rx_ready);
    @(negedge clk);
    check("R11 read alone keeps error", err_frame, 1);
    clear_all();
    check("R11 sequence clears error", err_frame, 0);

    // R10 DMA mode, R13 ready interrupt masked in DMA
    dma_en = 1'b1; ie_rdy = 1'b1;
    send(9'h0AA, 0, 0, 0, 0, 0, -1);
    check("R10 dma_req", dma_req, 1);
    check("R13 no ready irq in dma", irq, 0);
    pulse(rx_ready);
    @(negedge clk);
    check("R10 sw read ignored", rx_valid, 1);
    pulse(dma_ack);
    @(negedge clk);
    check("R10 dma ack clears", {rx_valid, dma_req}, 0);
    ie_rdy = 1'b0; ie_err = 1'b1;
    send(9'h0BB, 0, 0, 0, 0, 1, -1);
    check("R13 error irq in dma", irq, 1);
    pulse(dma_ack);
    clear_all();
    check("R13 irq drops", irq, 0);
    dma_en = 1'b0; ie_err = 1'b0;

    // R13 ready interrupt outside DMA
    ie_rdy = 1'b1;
    send(9'h012, 0, 0, 0, 0, 0, -1);
    check("R13 ready irq", irq, 1);
    clear_all();
    check("R13 ready irq clears", irq, 0);
    ie_rdy = 1'b0;

    // R7 break without and with LIN mode
    send(9'h000, 0, 0, 0, 0, 1, -1);
    check("R7 break as frame err", {rx_valid, err_frame, brk_flag}, 3'b110);
    check("R7 break data", rx_data, 0);
    clear_all();
    lin_en = 1'b1; ie_brk = 1'b1;
    send(9'h000, 0, 0, 0, 0, 1, -1);
    check("R7 lin break flag", {rx_valid, err_frame, brk_flag}, 3'b001);
    check("R7 break irq", irq, 1);
    clear_all();
    check("R7 break cleared", brk_flag, 0);
    lin_en = 1'b0; ie_brk = 1'b0;

    // R12 idle detection
    ie_idle = 1'b1;
    send(9'h077, 0, 0, 0, 0, 0, -1);
    clear_all();
    check("R12 idle not yet", idle_flag, 0);
    repeat (170) @(negedge clk);
    check("R12 idle set", idle_flag, 1);
    check("R13 idle irq", irq, 1);
    clear_all();
    ie_idle = 1'b0;

    // R14 flow control
    flow_en = 1'b1;
    @(negedge clk);
    check("R14 rts low when empty", rts_n, 0);
    send(9'h099, 0, 0, 0, 0, 0, -1);
    check("R14 rts high when full", rts_n, 1);
    clear_all();
    check("R14 rts low after read", rts_n, 0);
    flow_en = 1'b0;

    // R1 disabled receiver
    rx_en = 1'b0;
    send(9'h0E7, 0, 0, 0, 0, 0, -1);
    check("R1 rx_en low no frame", rx_valid, 0);
    rx_en = 1'b1; blk_en = 1'b0;
    send(9'h0E7, 0, 0, 0, 0, 0, -1);
    check("R1 blk_en low no frame", rx_valid, 0);
    blk_en = 1'b1;
    repeat (4) @(negedge clk);
    send(9'h0E7, 0, 0, 0, 0, 0, -1);
    check("R1 enabled again", rx_data, 9'h0E7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule